// File: doc/BRIEF.md
# Audio Serial Clock Generator with Mode-Strap Decoder

This block turns a three-bit strapping code into the operating set-up of a stereo audio converter's serial port. It also produces the port's bit clock and frame clock. The decoded set-up covers four things: whether the port is clock master or clock slave, whether DC-offset high-pass filtering is enabled, whether the logic-threshold select is the TTL one, and which master-clock-to-sample-rate ratios are allowed. One code is reserved. It raises an error flag and silences the clock outputs.

In master mode the block divides the master clock to make a bit clock at 64 times the sample rate and a frame clock at the sample rate. Both clocks have 50% duty. The code selects a master-clock ratio of 256, 384, 512 or 768 times the sample rate, so the bit-clock divide factor is 4, 6, 8 or 12. A high-rate hint input tells the block that the sample rate is above 48 kHz. In that case the 512x and 768x ratios are not allowed. In slave mode the block does not drive clocks of its own and passes the externally supplied bit and frame clocks through. A power-down input holds the master-mode clock outputs low and clears the dividers synchronously. Because of this, every release from power-down starts the clocks at the same phase.

Top module: `aclk_mode_gen`

## Requirements
- R1: Codes 000, 001 and 100 select slave mode and codes 010, 011, 110 and 111 select master mode (`is_master`=1). `hpf_en` is 1 for every code except 001 and 101. `ttl_lvl` is 1 only for code 100. At most one of `is_master`, `ttl_lvl` and `rsv_err` is high.
- R2: Code 101 sets `rsv_err`=1, clears `is_master`, `hpf_en`, `ttl_lvl` and all `ratio_ok` bits, and holds `bclk_o` and `lrclk_o` low whatever the external clocks do.
- R3: `ratio_ok` has bit 0 for 256x, bit 1 for 384x, bit 2 for 512x and bit 3 for 768x. In slave mode bits 0 and 1 are set, and bits 2 and 3 are set only when `hi_rate`=0. In master mode only the bit of the selected ratio can be set: 010 gives 256x, 110 gives 384x, 011 gives 512x and 111 gives 768x. Bits 2 and 3 are cleared when `hi_rate`=1.
- R4: In master mode with an allowed ratio, `bclk_o` is low at the first clock edge after power-down is released. After edge e it equals floor(e/H) mod 2, where H is the ratio divided by 128 (2, 3, 4 or 6).
- R5: In master mode `lrclk_o` starts low and toggles on every 32nd falling bit-clock edge. After edge e it equals floor(e/(64*H)) mod 2, and it changes only in a cycle where `bclk_o` falls.
- R6: While `pwr_dn`=1 in master mode, `bclk_o` and `lrclk_o` are low in that same cycle. After release, the clock sequence restarts at R4/R5 phase zero whatever point it had reached.
- R7: In slave mode `bclk_o` follows `ext_bclk` and `lrclk_o` follows `ext_lrclk` combinationally. `clk_oe` is 1 exactly when `is_master` is 1.
- R8: In master mode with a ratio that `hi_rate` does not allow (codes 011 and 111 with `hi_rate`=1), `bclk_o` and `lrclk_o` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all state is clocked on its rising edge |
| pwr_dn | input | 1 | Power-down, active high; clears dividers synchronously |
| mode_code | input | 3 | Strapping code |
| hi_rate | input | 1 | 1 when the sample rate is above 48 kHz |
| ext_bclk | input | 1 | Externally supplied bit clock (slave mode) |
| ext_lrclk | input | 1 | Externally supplied frame clock (slave mode) |
| bclk_o | output | 1 | Bit clock out |
| lrclk_o | output | 1 | Frame clock out |
| clk_oe | output | 1 | Drive enable for the clock pins (master mode) |
| is_master | output | 1 | Master role decoded |
| hpf_en | output | 1 | High-pass filter enable |
| ttl_lvl | output | 1 | TTL input-threshold select |
| ratio_ok | output | 4 | Allowed master-clock ratios {768x,512x,384x,256x} |
| rsv_err | output | 1 | Reserved code selected |

## Verification
The collision that matters is power-down arriving on the very edge where the frame counter would wrap and toggle the frame clock together with a falling bit clock. The bench runs the 384x mode for exactly one edge short of the second frame-clock toggle and then asserts power-down. It expects both clocks low in that cycle, with no toggle leaking through. After release it expects a full sequence that matches the phase-zero formula edge by edge. A second overlap, a ratio change while the divider is held, is covered by sweeping every code against both rate hints. Every new configuration must restart from the same phase.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

   localparam int RATIO_N = 4;

   typedef enum logic [1:0] {
      RAT_256 = 2'd0,
      RAT_384 = 2'd1,
      RAT_512 = 2'd2,
      RAT_768 = 2'd3
   } ratio_e;

   typedef struct packed {
      logic   master;
      logic   hpf_en;
      logic   ttl;
      logic   rsv;
      ratio_e ratio;
   } mode_s;

   // master clock cycles per sample for a ratio index
   function automatic int unsigned ratio_mult(input int unsigned idx);
      int unsigned base;
      base = ((idx % 2) != 0) ? 384 : 256;
      return (idx >= 2) ? base * 2 : base;
   endfunction

endpackage

// File: rtl/aclk_mode_dec.sv
module aclk_mode_dec
   import aclk_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic [CODE_W-1:0]  code,
   input  logic               hi_rate,
   output mode_s              mode,
   output logic [RATIO_N-1:0] ok_mask
);

   if (CODE_W != 3) begin : g_bad_code_w
      $error("aclk_mode_dec: CODE_W must be 3");
   end

   logic is_rsv;
   logic is_slave;

   assign is_rsv   = (code == 3'b101);
   assign is_slave = !code[1] && !is_rsv;

   always_comb begin
      mode.master = code[1];
      mode.rsv    = is_rsv;
      mode.ttl    = (code == 3'b100);
      mode.hpf_en = (code != 3'b001) && !is_rsv;
      // code bit 0 doubles the ratio, code bit 2 picks the 384 family
      mode.ratio  = ratio_e'({code[0], code[2]});
   end

   for (genvar i = 0; i < RATIO_N; i++) begin : g_mask
      localparam bit HIGH_OK = (i < 2);
      logic sel_hit;
      assign sel_hit    = (mode.ratio == ratio_e'(i));
      assign ok_mask[i] = (mode.master && sel_hit && (HIGH_OK || !hi_rate)) ||
                          (is_slave && (HIGH_OK || !hi_rate));
   end

endmodule

// File: rtl/aclk_bit_div.sv
module aclk_bit_div #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             clr,
   input  logic [CNT_W-1:0] half,
   output logic             bclk_q,
   output logic             fall_tick
);

   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("aclk_bit_div: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   assign wrap      = (cnt_q >= (half - CNT_W'(1)));
   assign fall_tick = !clr && wrap && bclk_q;

   always_ff @(posedge clk) begin
      if (clr) begin
         cnt_q  <= '0;
         bclk_q <= 1'b0;
      end else if (wrap) begin
         cnt_q  <= '0;
         bclk_q <= !bclk_q;
      end else begin
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div #(
   parameter int BITS_PER_HALF = 32
) (
   input  logic clk,
   input  logic clr,
   input  logic fall_tick,
   output logic lrclk_q
);

   localparam int FW = (BITS_PER_HALF > 2) ? $clog2(BITS_PER_HALF) : 1;
   localparam logic [FW-1:0] LAST = FW'(BITS_PER_HALF - 1);

   if (BITS_PER_HALF < 1) begin : g_bad_half
      $error("aclk_frame_div: BITS_PER_HALF must be positive");
   end

   logic [FW-1:0] bit_q;

   always_ff @(posedge clk) begin
      if (clr) begin
         bit_q   <= '0;
         lrclk_q <= 1'b0;
      end else if (fall_tick) begin
         if (bit_q == LAST) begin
            bit_q   <= '0;
            lrclk_q <= !lrclk_q;
         end else begin
            bit_q   <= bit_q + FW'(1);
         end
      end
   end

endmodule

// File: rtl/aclk_mode_gen.sv
module aclk_mode_gen
   import aclk_pkg::*;
#(
   parameter int CODE_W      = 3,
   parameter int BCLK_PER_FS = 64,
   parameter bit GATE_OUT    = 1'b1
) (
   input  logic              mclk,
   input  logic              pwr_dn,
   input  logic [CODE_W-1:0] mode_code,
   input  logic              hi_rate,
   input  logic              ext_bclk,
   input  logic              ext_lrclk,
   output logic              bclk_o,
   output logic              lrclk_o,
   output logic              clk_oe,
   output logic              is_master,
   output logic              hpf_en,
   output logic              ttl_lvl,
   output logic [3:0]        ratio_ok,
   output logic              rsv_err
);

   localparam int HALF_MAX = 768 / (2 * BCLK_PER_FS);
   localparam int HALF_W   = $clog2(HALF_MAX + 1);

   if (BCLK_PER_FS < 2 || BCLK_PER_FS > 64 ||
       (BCLK_PER_FS & (BCLK_PER_FS - 1)) != 0) begin : g_bad_fs
      $error("aclk_mode_gen: BCLK_PER_FS must be a power of two in 2..64");
   end

   mode_s              md;
   logic [RATIO_N-1:0] ok;
   logic               run;
   logic               clr;
   logic [HALF_W-1:0]  half_tab [RATIO_N];
   logic [HALF_W-1:0]  half_sel;
   logic               bclk_q;
   logic               lrclk_q;
   logic               fall_tick;
   logic               bclk_m;
   logic               lrclk_m;

   aclk_mode_dec #(.CODE_W(CODE_W)) u_dec (
      .code    (mode_code),
      .hi_rate (hi_rate),
      .mode    (md),
      .ok_mask (ok)
   );

   for (genvar i = 0; i < RATIO_N; i++) begin : g_half
      assign half_tab[i] = HALF_W'(ratio_mult(i) / (2 * BCLK_PER_FS));
   end

   assign half_sel = half_tab[md.ratio];
   assign run      = md.master && ok[md.ratio] && !pwr_dn;
   assign clr      = !run;

   aclk_bit_div #(.CNT_W(HALF_W)) u_bdiv (
      .clk       (mclk),
      .clr       (clr),
      .half      (half_sel),
      .bclk_q    (bclk_q),
      .fall_tick (fall_tick)
   );

   aclk_frame_div #(.BITS_PER_HALF(BCLK_PER_FS / 2)) u_fdiv (
      .clk       (mclk),
      .clr       (clr),
      .fall_tick (fall_tick),
      .lrclk_q   (lrclk_q)
   );

   if (GATE_OUT) begin : g_gated
      assign bclk_m  = bclk_q  && run;
      assign lrclk_m = lrclk_q && run;
   end else begin : g_raw
      assign bclk_m  = bclk_q;
      assign lrclk_m = lrclk_q;
   end

   always_comb begin
      if (md.master) begin
         bclk_o  = bclk_m;
         lrclk_o = lrclk_m;
      end else if (md.rsv) begin
         bclk_o  = 1'b0;
         lrclk_o = 1'b0;
      end else begin
         bclk_o  = ext_bclk;
         lrclk_o = ext_lrclk;
      end
   end

   assign clk_oe    = md.master;
   assign is_master = md.master;
   assign hpf_en    = md.hpf_en;
   assign ttl_lvl   = md.ttl;
   assign rsv_err   = md.rsv;
   assign ratio_ok  = ok;

endmodule

// File: rtl/aclk_mode_chk.sv
module aclk_mode_chk #(
   parameter int BCLK_PER_FS = 64
) (
   input logic       mclk,
   input logic       pwr_dn,
   input logic [2:0] mode_code,
   input logic       hi_rate,
   input logic       ext_bclk,
   input logic       ext_lrclk,
   input logic       bclk_o,
   input logic       lrclk_o,
   input logic       clk_oe,
   input logic       is_master,
   input logic       ttl_lvl,
   input logic [3:0] ratio_ok,
   input logic       rsv_err
);

   logic [7:0] hi_cnt;
   logic [7:0] exp_half;

   always_comb begin
      exp_half = 8'(((mode_code[2] ? 384 : 256) * (mode_code[0] ? 2 : 1)) / (2 * BCLK_PER_FS));
   end

   always_ff @(posedge mclk) begin
      if (pwr_dn || !bclk_o) hi_cnt <= '0;
      else                   hi_cnt <= hi_cnt + 8'd1;
   end

   always @(negedge mclk) begin
      if (pwr_dn && is_master)
         assert_pd_quiet_R6: assert (!bclk_o && !lrclk_o);
   end

   assert_rsv_quiet_R2: assert property (@(posedge mclk) disable iff (pwr_dn)
      rsv_err |-> (!bclk_o && !lrclk_o && ratio_ok == 4'b0000));

   assert_role_onehot_R1: assert property (@(posedge mclk) disable iff (pwr_dn)
      $onehot0({is_master, ttl_lvl, rsv_err}));

   assert_master_mask_R3: assert property (@(posedge mclk) disable iff (pwr_dn)
      is_master |-> ($countones(ratio_ok) <= 1));

   assert_slave_pass_R7: assert property (@(posedge mclk) disable iff (pwr_dn)
      (!is_master && !rsv_err) |-> (bclk_o == ext_bclk && lrclk_o == ext_lrclk && !clk_oe));

   assert_bclk_high_R4: assert property (@(posedge mclk) disable iff (pwr_dn || !is_master)
      $fell(bclk_o) |-> (hi_cnt == exp_half));

   assert_frame_on_fall_R5: assert property (@(posedge mclk) disable iff (pwr_dn || !is_master)
      !$stable(lrclk_o) |-> $fell(bclk_o));

   assert_unsup_quiet_R8: assert property (@(posedge mclk) disable iff (pwr_dn)
      (is_master && hi_rate && mode_code[0]) |-> (!bclk_o && !lrclk_o));

endmodule

bind aclk_mode_gen aclk_mode_chk #(.BCLK_PER_FS(BCLK_PER_FS)) u_chk (
   .mclk      (mclk),
   .pwr_dn    (pwr_dn),
   .mode_code (mode_code),
   .hi_rate   (hi_rate),
   .ext_bclk  (ext_bclk),
   .ext_lrclk (ext_lrclk),
   .bclk_o    (bclk_o),
   .lrclk_o   (lrclk_o),
   .clk_oe    (clk_oe),
   .is_master (is_master),
   .ttl_lvl   (ttl_lvl),
   .ratio_ok  (ratio_ok),
   .rsv_err   (rsv_err)
);

// File: tb/aclk_mode_gen_tb.sv
module aclk_mode_gen_tb;

   logic       mclk = 1'b0;
   logic       pwr_dn = 1'b1;
   logic [2:0] mode_code = 3'b000;
   logic       hi_rate = 1'b0;
   logic       ext_bclk = 1'b0;
   logic       ext_lrclk = 1'b0;
   logic       bclk_o, lrclk_o, clk_oe, is_master, hpf_en, ttl_lvl, rsv_err;
   logic [3:0] ratio_ok;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 mclk = !mclk;

   aclk_mode_gen u_dut (
      .mclk(mclk), .pwr_dn(pwr_dn), .mode_code(mode_code), .hi_rate(hi_rate),
      .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
      .clk_oe(clk_oe), .is_master(is_master), .hpf_en(hpf_en), .ttl_lvl(ttl_lvl),
      .ratio_ok(ratio_ok), .rsv_err(rsv_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (code %0d hint %0d)",
                  req, what, act, exp, mode_code, hi_rate);
      end
   endtask

   function automatic int half_of(input int c);
      return (((c & 4) != 0 ? 384 : 256) * ((c & 1) != 0 ? 2 : 1)) / 128;
   endfunction

   function automatic int mask_of(input int c, input int h);
      int m = 0;
      int idx = ((c & 1) << 1) | ((c >> 2) & 1);
      for (int i = 0; i < 4; i++) begin
         if ((c & 2) != 0) begin
            if (i == idx && (h == 0 || i < 2)) m |= (1 << i);
         end else if (c != 5) begin
            if (i < 2 || h == 0) m |= (1 << i);
         end
      end
      return m;
   endfunction

   // releases power-down and follows n edges of the master clock sequence
   task automatic run_master(input int c, input int h, input int n);
      int hf = half_of(c);
      bit ok_rate = (h == 0) || ((c & 1) == 0);
      @(negedge mclk) pwr_dn = 1'b0;
      for (int e = 1; e <= n; e++) begin
         @(posedge mclk);
         @(negedge mclk);
         if (ok_rate) begin
            chk("R4", "bclk", int'(bclk_o), (e / hf) % 2);
            chk("R5", "lrclk", int'(lrclk_o), (e / (64 * hf)) % 2);
         end else begin
            chk("R8", "bclk", int'(bclk_o), 0);
            chk("R8", "lrclk", int'(lrclk_o), 0);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge mclk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge mclk);
      // reset state: slave code 000 under power-down
      chk("R7", "reset clk_oe", int'(clk_oe), 0);
      chk("R1", "reset hpf_en", int'(hpf_en), 1);
      chk("R7", "reset bclk", int'(bclk_o), 0);

      for (int c = 0; c < 8; c++) begin
         for (int h = 0; h < 2; h++) begin
            @(negedge mclk);
            pwr_dn = 1'b1; mode_code = 3'(c); hi_rate = 1'(h);
            ext_bclk = 1'b1; ext_lrclk = 1'b1;
            repeat (2) @(negedge mclk);
            chk("R1", "is_master", int'(is_master), (c & 2) != 0 ? 1 : 0);
            chk("R1", "hpf_en", int'(hpf_en), (c != 1 && c != 5) ? 1 : 0);
            chk("R1", "ttl_lvl", int'(ttl_lvl), c == 4 ? 1 : 0);
            chk("R2", "rsv_err", int'(rsv_err), c == 5 ? 1 : 0);
            chk("R3", "ratio_ok", int'(ratio_ok), mask_of(c, h));
            chk("R7", "clk_oe", int'(clk_oe), (c & 2) != 0 ? 1 : 0);
            if ((c & 2) != 0) begin
               chk("R6", "pd bclk", int'(bclk_o), 0);
               chk("R6", "pd lrclk", int'(lrclk_o), 0);
               ext_bclk = 1'b0; ext_lrclk = 1'b0;
               run_master(c, h, 128 * half_of(c) + 10);
            end else begin
               @(negedge mclk) pwr_dn = 1'b0;
               for (int p = 0; p < 8; p++) begin
                  @(negedge mclk);
                  ext_bclk = p[0]; ext_lrclk = p[1] ^ p[2];
                  #1;
                  if (c == 5) begin
                     chk("R2", "rsv bclk", int'(bclk_o), 0);
                     chk("R2", "rsv lrclk", int'(lrclk_o), 0);
                  end else begin
                     chk("R7", "pass bclk", int'(bclk_o), int'(ext_bclk));
                     chk("R7", "pass lrclk", int'(lrclk_o), int'(ext_lrclk));
                  end
               end
            end
         end
      end

      // power-down lands on the edge that would toggle the frame clock
      @(negedge mclk);
      pwr_dn = 1'b1; mode_code = 3'b110; hi_rate = 1'b0;
      ext_bclk = 1'b0; ext_lrclk = 1'b0;
      repeat (2) @(negedge mclk);
      run_master(6, 0, 2 * 64 * 3 - 1);
      pwr_dn = 1'b1;
      #1;
      chk("R6", "pd same-cycle bclk", int'(bclk_o), 0);
      chk("R6", "pd same-cycle lrclk", int'(lrclk_o), 0);
      @(posedge mclk);
      @(negedge mclk);
      chk("R6", "held lrclk", int'(lrclk_o), 0);
      chk("R6", "held bclk", int'(bclk_o), 0);
      run_master(6, 0, 2 * 64 * 3 + 10);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule